// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block resolves a virtual address into a physical address once a translation cache has missed. It reads up to three page-table entries in sequence from memory through a single read port, where each read depends on the one before it. The first read is taken from a root table whose physical address is supplied with the request. A valid upper-level entry names the frame that holds the next table. The entry read from the bottom level is the leaf. Its frame number is placed above the untranslated page offset to form the physical address.

The walk checks only the valid bit of the two upper-level entries. Read and write permission come from the leaf alone, and the bit that is consulted depends on whether the access is a user or a kernel access. A finished walk raises a one-cycle completion strobe. With it come the physical address, the entry on which the walk ended (so a translation cache can be refilled from it) and a two-bit fault code. The walker accepts one request at a time and keeps at most one memory read in flight.

Top module: `pt_walker`

## Requirements
- R1: After reset, busy, done, mem_rd_valid, fault and paddr are all zero.
- R2: A request is taken only while busy is low. busy is high from the cycle after acceptance until the cycle in which done is high, and busy is low in that cycle. A request presented while busy is high is ignored and causes no memory read.
- R3: The virtual address is 43 bits wide. Bits [12:0] are the page offset, bits [42:33] are the first index, bits [32:23] are the second index and bits [22:13] are the third index. The first read address is ptbr + 8 × first index.
- R4: Each following read address is (frame number of the previous entry × 8192) + 8 × the index for that level.
- R5: mem_rd_valid is high for exactly one cycle per read. No new read is issued before the response to the previous read has arrived, and a walk performs at most three reads.
- R6: An entry is 64 bits. Bits [31:0] hold the frame number. Bit 32 is valid, bit 33 is user read, bit 34 is kernel read, bit 35 is user write and bit 36 is kernel write.
- R7: When the walk succeeds, done rises in the cycle after the leaf response. In that cycle fault is 0, paddr equals {leaf frame number, offset} and leaf_pte equals the leaf entry. These outputs hold until the next completion.
- R8: If an entry at any level has valid = 0, the walk ends with fault code 1 and issues no further reads.
- R9: The permission bits of the first- and second-level entries are ignored. An upper-level entry that is valid but has no permission bits set still lets the walk continue.
- R10: A read is allowed by bit 33 for user accesses and by bit 34 for kernel accesses. A denied read gives fault code 2.
- R11: A write is allowed by bit 35 for user accesses and by bit 36 for kernel accesses, and the read bits are not consulted. A denied write gives fault code 3.
- R12: When a walk ends with a fault, paddr is zero and leaf_pte holds the entry on which the walk stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request, taken while idle |
| req_vaddr | input | 43 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_user | input | 1 | 1 = user access, 0 = kernel access |
| ptbr | input | 45 | Physical address of the root table |
| busy | output | 1 | Walk in progress |
| mem_rd_valid | output | 1 | One-cycle memory read strobe |
| mem_rd_addr | output | 45 | Address of the entry to read |
| mem_rsp_valid | input | 1 | Read response strobe |
| mem_rsp_data | input | 64 | Entry returned by memory |
| done | output | 1 | One-cycle completion strobe |
| paddr | output | 45 | Translated physical address, zero on fault |
| leaf_pte | output | 64 | Entry on which the walk ended |
| fault | output | 2 | 0 none, 1 invalid, 2 read denied, 3 write denied |

## Verification
The assertions assume that memory returns exactly one response for each read, never in the same cycle as the read strobe, and never while no read is pending. The bench's memory responder counts down a latency of at least one cycle from each strobe it sees, then raises mem_rsp_valid for a single cycle. It does not produce a response unless a read is pending. Requests are driven only while the walker is idle, except in one deliberate case. In that case a request is held for a single cycle in mid-walk, and the bench confirms that the read sequence is not disturbed.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int OFF_W = 13,
  parameter int IDX_W = 10,
  parameter int PFN_W = 32,
  localparam int VA_W = OFF_W + 3 * IDX_W,
  localparam int PA_W = PFN_W + OFF_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic            req_write,
  input  logic            req_user,
  input  logic [PA_W-1:0] ptbr,
  output logic            busy,
  output logic            mem_rd_valid,
  output logic [PA_W-1:0] mem_rd_addr,
  input  logic            mem_rsp_valid,
  input  logic [63:0]     mem_rsp_data,
  output logic            done,
  output logic [PA_W-1:0] paddr,
  output logic [63:0]     leaf_pte,
  output logic [1:0]      fault
);
  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_t;

  st_t             state;
  logic [1:0]      lvl;
  logic [VA_W-1:0] va_q;
  logic            wr_q, usr_q;
  logic [PA_W-1:0] base_q;
  logic [IDX_W-1:0] idx;

  always_comb begin
    case (lvl)
      2'd0:    idx = va_q[OFF_W+2*IDX_W +: IDX_W];
      2'd1:    idx = va_q[OFF_W+IDX_W +: IDX_W];
      default: idx = va_q[OFF_W +: IDX_W];
    endcase
  end

  assign mem_rd_addr  = base_q + {{(PA_W-IDX_W-3){1'b0}}, idx, 3'b000};
  assign mem_rd_valid = (state == S_REQ);
  assign busy         = (state != S_IDLE);

  wire pte_v  = mem_rsp_data[PFN_W];
  wire can_rd = usr_q ? mem_rsp_data[PFN_W+1] : mem_rsp_data[PFN_W+2];
  wire can_wr = usr_q ? mem_rsp_data[PFN_W+3] : mem_rsp_data[PFN_W+4];
  wire [1:0] leaf_code = wr_q ? (can_wr ? 2'd0 : 2'd3) : (can_rd ? 2'd0 : 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      lvl      <= 2'd0;
      va_q     <= '0;
      wr_q     <= 1'b0;
      usr_q    <= 1'b0;
      base_q   <= '0;
      done     <= 1'b0;
      paddr    <= '0;
      leaf_pte <= '0;
      fault    <= 2'd0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          va_q   <= req_vaddr;
          wr_q   <= req_write;
          usr_q  <= req_user;
          base_q <= ptbr;
          lvl    <= 2'd0;
          state  <= S_REQ;
        end
        S_REQ: state <= S_WAIT;
        default: if (mem_rsp_valid) begin
          if (pte_v && lvl != 2'd2) begin
            base_q <= {mem_rsp_data[PFN_W-1:0], {OFF_W{1'b0}}};
            lvl    <= lvl + 2'd1;
            state  <= S_REQ;
          end else begin
            state    <= S_IDLE;
            done     <= 1'b1;
            leaf_pte <= mem_rsp_data;
            fault    <= pte_v ? leaf_code : 2'd1;
            paddr    <= (pte_v && leaf_code == 2'd0) ?
                        {mem_rsp_data[PFN_W-1:0], va_q[OFF_W-1:0]} : '0;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int OFF_W = 13,
  parameter int IDX_W = 10,
  parameter int PFN_W = 32,
  localparam int VA_W = OFF_W + 3 * IDX_W,
  localparam int PA_W = PFN_W + OFF_W
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [VA_W-1:0] req_vaddr,
  input logic            req_write,
  input logic            req_user,
  input logic            busy,
  input logic            mem_rd_valid,
  input logic            mem_rsp_valid,
  input logic            done,
  input logic [PA_W-1:0] paddr,
  input logic [63:0]     leaf_pte,
  input logic [1:0]      fault
);
  logic [OFF_W-1:0] off_q;
  logic             wr_q, usr_q, pend;
  logic [2:0]       rd_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0; wr_q <= 1'b0; usr_q <= 1'b0; pend <= 1'b0; rd_cnt <= '0;
    end else begin
      if (req_valid && !busy) begin
        off_q  <= req_vaddr[OFF_W-1:0];
        wr_q   <= req_write;
        usr_q  <= req_user;
        rd_cnt <= '0;
      end else if (mem_rd_valid) rd_cnt <= rd_cnt + 3'd1;
      if (mem_rd_valid) pend <= 1'b1;
      else if (mem_rsp_valid) pend <= 1'b0;
    end
  end

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n) mem_rd_valid |-> !pend); // R5
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n) mem_rd_valid |=> !mem_rd_valid); // R5
  AST_READ_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) done |-> (rd_cnt >= 3'd1 && rd_cnt <= 3'd3)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R7
  AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R2
  AST_PA_JOIN: assert property (@(posedge clk) disable iff (!rst_n) (done && fault == 2'd0) |-> paddr == {leaf_pte[PFN_W-1:0], off_q}); // R7
  AST_FULL_WALK: assert property (@(posedge clk) disable iff (!rst_n) (done && fault != 2'd1) |-> rd_cnt == 3'd3); // R9
  AST_INVALID_STOP: assert property (@(posedge clk) disable iff (!rst_n) (done && fault == 2'd1) |-> !leaf_pte[PFN_W]); // R8
  AST_READ_PERM: assert property (@(posedge clk) disable iff (!rst_n) (done && fault == 2'd0 && !wr_q) |-> (usr_q ? leaf_pte[PFN_W+1] : leaf_pte[PFN_W+2])); // R10
  AST_WRITE_PERM: assert property (@(posedge clk) disable iff (!rst_n) (done && fault == 2'd0 && wr_q) |-> (usr_q ? leaf_pte[PFN_W+3] : leaf_pte[PFN_W+4])); // R11
  AST_FAULT_NO_PA: assert property (@(posedge clk) disable iff (!rst_n) (done && fault != 2'd0) |-> paddr == '0); // R12
endmodule

bind pt_walker pt_walker_chk #(.OFF_W(OFF_W), .IDX_W(IDX_W), .PFN_W(PFN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
  .req_write(req_write), .req_user(req_user), .busy(busy),
  .mem_rd_valid(mem_rd_valid), .mem_rsp_valid(mem_rsp_valid), .done(done),
  .paddr(paddr), .leaf_pte(leaf_pte), .fault(fault)
);

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
  localparam int VA_W = 43;
  localparam int PA_W = 45;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [VA_W-1:0] req_vaddr = '0;
  logic [PA_W-1:0] ptbr = '0;
  logic busy, mem_rd_valid, done;
  logic [PA_W-1:0] mem_rd_addr, paddr;
  logic mem_rsp_valid;
  logic [63:0] mem_rsp_data, leaf_pte;
  logic [1:0] fault;

  pt_walker u_pt_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_user(req_user), .ptbr(ptbr), .busy(busy),
    .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done(done), .paddr(paddr), .leaf_pte(leaf_pte), .fault(fault)
  );

  always #4 clk = ~clk;

  int tests = 0, fails = 0, lat = 1, cycles = 0;
  bit finished = 0;
  logic [63:0] mem [logic [PA_W-1:0]];
  logic [PA_W-1:0] exp_addr [$];
  logic [1:0]      exp_fault [$];
  logic [PA_W-1:0] exp_pa [$];
  logic [63:0]     exp_pte [$];
  string           exp_tag [$];

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  function automatic logic [63:0] rd(input logic [PA_W-1:0] a);
    return mem.exists(a) ? mem[a] : 64'd0;
  endfunction

  // ctl order {kernel write, user write, kernel read, user read, valid}
  function automatic logic [63:0] pte(input logic [31:0] pfn, input logic [4:0] ctl);
    return {27'd0, ctl, pfn};
  endfunction

  function automatic logic [VA_W-1:0] mkva(input int i1, input int i2, input int i3, input int off);
    return {i1[9:0], i2[9:0], i3[9:0], off[12:0]};
  endfunction

  task automatic map(input logic [VA_W-1:0] va, input logic [31:0] p1, input logic [4:0] c1,
                     input logic [31:0] p2, input logic [4:0] c2, input logic [63:0] leaf);
    mem[ptbr + {va[42:33], 3'b000}] = pte(p1, c1);
    mem[{p1, 13'd0} + {va[32:23], 3'b000}] = pte(p2, c2);
    mem[{p2, 13'd0} + {va[22:13], 3'b000}] = leaf;
  endtask

  task automatic predict(input logic [VA_W-1:0] va, input bit wr, input bit usr, input string tag);
    logic [PA_W-1:0] base = ptbr;
    logic [63:0] e = 0;
    logic [1:0] f = 0;
    for (int l = 0; l < 3; l++) begin
      int ix = (l == 0) ? int'(va[42:33]) : (l == 1) ? int'(va[32:23]) : int'(va[22:13]);
      logic [PA_W-1:0] a = base + PA_W'(ix * 8);
      exp_addr.push_back(a);
      e = rd(a);
      if (!e[32]) begin f = 2'd1; break; end
      base = {e[31:0], 13'd0};
    end
    if (f == 0) begin
      if (wr) f = (usr ? e[35] : e[36]) ? 2'd0 : 2'd3;
      else    f = (usr ? e[33] : e[34]) ? 2'd0 : 2'd2;
    end
    exp_fault.push_back(f);
    exp_pa.push_back(f == 0 ? {e[31:0], va[12:0]} : '0);
    exp_pte.push_back(e);
    exp_tag.push_back(tag);
  endtask

  task automatic walk(input logic [VA_W-1:0] va, input bit wr, input bit usr, input int l,
                      input bit spur, input string tag);
    lat = l;
    predict(va, wr, usr, tag);
    req_vaddr = va; req_write = wr; req_user = usr; req_valid = 1'b1;
    @(negedge clk);
    check({"R2 busy after accept ", tag}, 64'(busy), 64'd1);
    if (spur) begin
      req_vaddr = ~va; req_write = ~wr;
      @(negedge clk);
    end
    req_valid = 1'b0;
    while (busy) @(negedge clk);
  endtask

  initial begin
    int cnt = 0;
    logic [PA_W-1:0] pa = 0;
    mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin mem_rsp_valid = 1'b1; mem_rsp_data = rd(pa); end
      end else if (mem_rd_valid) begin
        pa = mem_rd_addr; cnt = lat;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && mem_rd_valid) begin
        if (exp_addr.size() == 0) check("R2 R5 unexpected read", 64'(mem_rd_addr), 64'hx);
        else check("R3 R4 read address", 64'(mem_rd_addr), 64'(exp_addr.pop_front()));
      end
      if (rst_n && done) begin
        if (exp_fault.size() == 0) check("R2 unexpected done", 64'd1, 64'd0);
        else begin
          string t = exp_tag.pop_front();
          check({"R7 R8 R10 R11 fault ", t}, 64'(fault), 64'(exp_fault.pop_front()));
          check({"R7 R12 paddr ", t}, 64'(paddr), 64'(exp_pa.pop_front()));
          check({"R7 R12 leaf_pte ", t}, leaf_pte, exp_pte.pop_front());
          check({"R2 idle at done ", t}, 64'(busy), 64'd0);
        end
      end
    end
  end

  initial begin
    while (cycles < 100000) begin @(posedge clk); cycles++; end
    fails++; tests++;
    $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
    finish_up();
  end

  initial begin
    logic [VA_W-1:0] va;
    ptbr = 45'h0000_0012_0000;
    repeat (3) @(negedge clk);
    check("R1 busy", 64'(busy), 0);
    check("R1 done", 64'(done), 0);
    check("R1 mem_rd_valid", 64'(mem_rd_valid), 0);
    check("R1 fault", 64'(fault), 0);
    check("R1 paddr", 64'(paddr), 0);
    rst_n = 1'b1;
    @(negedge clk);

    va = mkva(5, 7, 9, 13'h1abc);
    map(va, 32'h100, 5'b00001, 32'h200, 5'b00001, pte(32'hdead_beef, 5'b00011));
    walk(va, 0, 1, 1, 0, "R6 R7 user read ok");

    va = mkva(1023, 1023, 1023, 13'h1fff);
    map(va, 32'h101, 5'b00001, 32'h201, 5'b00001, pte(32'h0000_1234, 5'b10001));
    walk(va, 1, 0, 3, 0, "R3 R4 kernel write max index");

    walk(mkva(6, 0, 0, 5), 0, 0, 2, 0, "R8 invalid level1");

    va = mkva(8, 3, 4, 0);
    mem[ptbr + {va[42:33], 3'b000}] = pte(32'h102, 5'b11110);
    walk(va, 0, 0, 1, 0, "R8 R12 invalid level1 with perms");

    va = mkva(9, 3, 4, 0);
    mem[ptbr + {va[42:33], 3'b000}] = pte(32'h103, 5'b00001);
    mem[{32'h103, 13'd0} + {va[32:23], 3'b000}] = pte(32'h333, 5'b11110);
    walk(va, 0, 0, 2, 0, "R8 invalid level2");

    va = mkva(10, 11, 12, 13'h0042);
    map(va, 32'h104, 5'b00001, 32'h204, 5'b00001, pte(32'h55, 5'b11110));
    walk(va, 0, 1, 1, 0, "R8 R12 invalid leaf");

    va = mkva(11, 12, 13, 13'h0777);
    map(va, 32'h105, 5'b00001, 32'h205, 5'b00001, pte(32'h9999, 5'b00101));
    walk(va, 0, 0, 1, 0, "R9 R10 upper no perms kernel read ok");
    walk(va, 0, 1, 4, 0, "R10 R12 user read denied");
    walk(va, 1, 0, 1, 0, "R11 kernel write denied");

    va = mkva(12, 13, 14, 13'h0100);
    map(va, 32'h106, 5'b11111, 32'h206, 5'b11111, pte(32'h4444, 5'b01011));
    walk(va, 0, 0, 1, 0, "R10 kernel read denied");
    walk(va, 1, 1, 1, 0, "R11 user write ok");
    walk(va, 1, 0, 2, 0, "R11 kernel write denied only uw");

    va = mkva(13, 14, 15, 13'h0003);
    map(va, 32'h107, 5'b00001, 32'h207, 5'b00001, pte(32'h7777, 5'b11001));
    walk(va, 1, 1, 1, 0, "R11 write without read bits");
    walk(va, 0, 1, 1, 0, "R10 read denied write-only");

    walk(mkva(5, 7, 9, 13'h0001), 0, 1, 1, 1, "R2 request while busy ignored");
    walk(mkva(6, 1, 1, 1), 1, 1, 1, 1, "R2 R8 ignored during short walk");

    repeat (6) @(negedge clk);
    check("R2 R5 no stray reads left", 64'(exp_addr.size()), 0);
    check("R7 no missing completions", 64'(exp_fault.size()), 0);
    finish_up();
  end
endmodule